// File: doc/BRIEF.md
# FPGA Serial Configuration Sequencer

This block loads a configuration image into a target FPGA over a serial, SPI-like slave link. After a start pulse it holds the target in reset, confirms that the target's done line is low, and waits a settle delay. It then sends a burst of free-running clocks with chip-select high, and streams the image bytes with chip-select low. A second burst of free-running clocks with chip-select high follows. The block ends by reading the done line to decide between success and failure.

Image bytes arrive on a valid/ready byte stream. The byte count is latched with the start pulse. The serial clock is divided from the system clock by a half-period count. All timings and clock counts are parameters. While idle, the block keeps reset and chip-select high and tri-states clock and data through their output enables.

Top module: `fpga_cfg_loader`

## Requirements
- R1: On an accepted start, `creset_n` and `cs_n` go low in the same cycle, and `creset_n` stays low for exactly RST_CYC cycles.
- R2: If the synchronized done line is high when the reset hold ends, the load ends with `err`=1 and `ok`=0. No serial clock falls, and `creset_n` and `cs_n` return high.
- R3: After reset is released, `cs_n` stays low with `creset_n` high for exactly SETTLE_CYC cycles, and then rises.
- R4: Exactly LEAD_CLKS rising serial clock edges are sent while `cs_n` is high, before the data phase.
- R5: In the data phase (`cs_n` low), the bench captures exactly 8×length bits, one on each rising serial clock edge. Each byte is sent most significant bit first. `sdo_o` changes only while `sclk_o` is low.
- R6: After the data phase, `cs_n` rises, and exactly TRAIL_CLKS rising serial clock edges are sent with `cs_n` high.
- R7: After the trailing clocks, `ok`=1 and `err`=0 if the synchronized done line is high; otherwise `ok`=0 and `err`=1. The flags never are both 1, and they hold until the next accepted start.
- R8: Every low phase of the serial clock lasts exactly HALF system cycles.
- R9: While `busy` is 0, `creset_n`=1, `cs_n`=1, and `sclk_oe`=`sdo_oe`=0. While `busy` is 1, both output enables are 1.
- R10: `s_ready` is 1 only in the data phase, only after a byte's 8th rising edge, and only while bytes remain. A byte that has not arrived stalls the serial clock high.
- R11: A start pulse while `busy` is 1 is ignored: the running load keeps its original byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| img_len | input | LEN_W | Image length in bytes, latched at start |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_ready | output | 1 | Block takes a byte this cycle when valid |
| done_in | input | 1 | Target's configuration-done line (asynchronous) |
| creset_n | output | 1 | Target reset, active low |
| cs_n | output | 1 | Target chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| sdo_o | output | 1 | Serial data to target |
| sdo_oe | output | 1 | Serial data output enable |
| busy | output | 1 | A load sequence is in progress |
| ok | output | 1 | Last load finished with done high |
| err | output | 1 | Last load aborted or finished with done low |

## Verification
Two events can fall in the same cycle: a byte handshake and the expiry of the serial clock's high half-period. The handshake must win, and the next falling edge must wait for the accepted byte. Otherwise the clock would fall with no data loaded. The bench provokes this by sweeping image lengths with and without idle gaps between bytes. It judges the result from the captured bit stream, the count of clock edges per phase, and a check that the clock is high whenever a byte is awaited. A second collision comes from a start pulse during a running load. The bench judges it by the number of data bits that follow.

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int HALF       = 125,
  parameter int RST_CYC    = 64,
  parameter int SETTLE_CYC = 300,
  parameter int LEAD_CLKS  = 8,
  parameter int TRAIL_CLKS = 49,
  parameter int LEN_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             done_in,
  output logic             creset_n,
  output logic             cs_n,
  output logic             sclk_o,
  output logic             sclk_oe,
  output logic             sdo_o,
  output logic             sdo_oe,
  output logic             busy,
  output logic             ok,
  output logic             err
);
  localparam int TMAX0 = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int TMAX  = (TMAX0 > HALF) ? TMAX0 : HALF;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PMAX  = (LEAD_CLKS > TRAIL_CLKS) ? LEAD_CLKS : TRAIL_CLKS;
  localparam int PW    = $clog2(PMAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_SET, S_LEAD, S_DATA, S_TRAIL} st_t;

  st_t             st;
  logic [TW-1:0]   tcnt;
  logic [PW-1:0]   pcnt;
  logic [LEN_W-1:0] left;
  logic [7:0]      sreg;
  logic [3:0]      bitn;
  logic [1:0]      dq;

  assign busy    = (st != S_IDLE);
  assign sclk_oe = busy;
  assign sdo_oe  = busy;
  assign s_ready = (st == S_DATA) && (bitn == 4'd0) && (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tcnt     <= '0;
      pcnt     <= '0;
      left     <= '0;
      sreg     <= '0;
      bitn     <= '0;
      dq       <= '0;
      creset_n <= 1'b1;
      cs_n     <= 1'b1;
      sclk_o   <= 1'b1;
      sdo_o    <= 1'b1;
      ok       <= 1'b0;
      err      <= 1'b0;
    end else begin
      dq <= {dq[0], done_in};
      if (tcnt != '0) tcnt <= tcnt - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          ok       <= 1'b0;
          err      <= 1'b0;
          left     <= img_len;
          bitn     <= '0;
          creset_n <= 1'b0;
          cs_n     <= 1'b0;
          sclk_o   <= 1'b1;
          sdo_o    <= 1'b1;
          tcnt     <= TW'(RST_CYC - 1);
          st       <= S_RST;
        end
        S_RST: if (tcnt == '0) begin
          creset_n <= 1'b1;
          if (dq[1]) begin
            err  <= 1'b1;
            cs_n <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tcnt <= TW'(SETTLE_CYC - 1);
            st   <= S_SET;
          end
        end
        S_SET: if (tcnt == '0) begin
          cs_n <= 1'b1;
          pcnt <= PW'(LEAD_CLKS);
          tcnt <= TW'(HALF - 1);
          st   <= S_LEAD;
        end
        S_LEAD, S_TRAIL: if (tcnt == '0) begin
          tcnt <= TW'(HALF - 1);
          if (!sclk_o) sclk_o <= 1'b1;
          else if (pcnt != '0) begin
            sclk_o <= 1'b0;
            pcnt   <= pcnt - 1'b1;
          end else if (st == S_LEAD) begin
            cs_n <= 1'b0;
            st   <= S_DATA;
          end else begin
            ok  <= dq[1];
            err <= !dq[1];
            st  <= S_IDLE;
          end
        end
        S_DATA: begin
          if (s_valid && s_ready) begin
            sreg <= s_data;
            bitn <= 4'd8;
            left <= left - 1'b1;
          end else if (tcnt == '0) begin
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              sreg   <= {sreg[6:0], 1'b0};
              bitn   <= bitn - 1'b1;
              tcnt   <= TW'(HALF - 1);
            end else if (bitn != 4'd0) begin
              sclk_o <= 1'b0;
              sdo_o  <= sreg[7];
              tcnt   <= TW'(HALF - 1);
            end else if (left == '0) begin
              cs_n <= 1'b1;
              pcnt <= PW'(TRAIL_CLKS);
              tcnt <= TW'(HALF - 1);
              st   <= S_TRAIL;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_cfg_loader_chk.sv
module fpga_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ok,
  input logic err,
  input logic creset_n,
  input logic cs_n,
  input logic sclk_o,
  input logic sclk_oe,
  input logic sdo_o,
  input logic sdo_oe,
  input logic s_ready
);
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_oe && !sdo_oe && creset_n && cs_n));

  p_busy_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sclk_oe && sdo_oe));

  p_reset_with_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !creset_n |-> !cs_n);

  p_clock_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !sclk_o) |-> creset_n);

  p_data_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && (sdo_o != $past(sdo_o))) |-> !sclk_o);

  p_stall_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (sclk_o && !cs_n));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(ok) && $stable(err)));
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ok(ok), .err(err),
  .creset_n(creset_n), .cs_n(cs_n), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .sdo_o(sdo_o), .sdo_oe(sdo_oe), .s_ready(s_ready)
);

// File: tb/fpga_cfg_loader_tb.sv
`timescale 1ns/1ps
module fpga_cfg_loader_tb;
  localparam int HALF = 2, RSTC = 5, SETC = 3, LEAD = 3, TRAIL = 4, LW = 4;

  logic clk = 0, rst_n = 0, start = 0, s_valid = 0, done_in = 0;
  logic [LW-1:0] img_len = '0;
  logic [7:0] s_data = '0;
  logic s_ready, creset_n, cs_n, sclk_o, sclk_oe, sdo_o, sdo_oe, busy, ok, err;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fpga_cfg_loader #(.HALF(HALF), .RST_CYC(RSTC), .SETTLE_CYC(SETC),
    .LEAD_CLKS(LEAD), .TRAIL_CLKS(TRAIL), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .done_in(done_in),
    .creset_n(creset_n), .cs_n(cs_n), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .busy(busy), .ok(ok), .err(err));

  task automatic chk(input bit c, input string req, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int run, input int idx);
    return 8'((run * 37 + idx * 91 + 5) & 255);
  endfunction

  int   rst_low, settle, lead_r, data_r, trail_r, low_bad, sdo_bad, rdy_bad, fall_cnt;
  int   seg;
  logic [7:0] cap [0:15];
  logic [7:0] shreg;

  task automatic feed(input int run, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      s_valid = 0;
      repeat ((gap == 0) ? 0 : ((i + run) % gap) * 7) @(negedge clk);
      s_valid = 1;
      s_data  = pat(run, i);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0;
  endtask

  task automatic watch(input bit want_done, input bit busy_start);
    logic p_sclk, p_sdo;
    int lowc = 0, smp = 0;
    p_sclk = sclk_o; p_sdo = sdo_o;
    while (busy) begin
      smp++;
      if (busy_start && smp == 14) begin start = 1; img_len = 4'd15; end
      if (busy_start && smp == 15) start = 0;
      if (!creset_n) rst_low++;
      if (creset_n && !cs_n && seg == 0) settle++;
      if (seg == 0 && creset_n && cs_n && settle > 0) seg = 1;
      if (seg == 1 && !cs_n) seg = 2;
      if (seg == 2 && cs_n) begin seg = 3; if (want_done) done_in = 1; end
      if (p_sclk && !sclk_o) fall_cnt++;
      if (!sclk_o) lowc++;
      if (!p_sclk && sclk_o) begin
        if (lowc != HALF) low_bad++;
        lowc = 0;
        if (seg == 1) lead_r++;
        if (seg == 3) trail_r++;
        if (seg == 2) begin
          shreg = {shreg[6:0], sdo_o};
          data_r++;
          if (data_r % 8 == 0) cap[(data_r / 8 - 1) & 15] = shreg;
        end
      end
      if (sdo_o != p_sdo && sclk_o) sdo_bad++;
      if (s_ready && (!sclk_o || (data_r % 8) != 0 || seg != 2)) rdy_bad++;
      p_sclk = sclk_o; p_sdo = sdo_o;
      @(negedge clk);
    end
  endtask

  task automatic run(input int r, input int len, input int gap, input bit want_done,
                     input bit abort_case, input bit busy_start);
    logic ok0, err0;
    rst_low = 0; settle = 0; lead_r = 0; data_r = 0; trail_r = 0;
    low_bad = 0; sdo_bad = 0; rdy_bad = 0; fall_cnt = 0; seg = 0; shreg = 0;
    done_in = abort_case;
    repeat (3) @(negedge clk);
    start = 1; img_len = LW'(len);
    @(negedge clk);
    start = 0;
    chk(busy && sclk_oe && sdo_oe, "R9 busy drives", busy, 1);
    chk(!creset_n && !cs_n, "R1 reset and cs low together", {creset_n, cs_n}, 0);
    fork
      feed(r, abort_case ? 0 : len, gap);
      watch(want_done, busy_start);
    join
    chk(rst_low == RSTC, "R1 reset hold", rst_low, RSTC);
    chk(creset_n && cs_n && !sclk_oe && !sdo_oe, "R9 idle release",
        {creset_n, cs_n, sclk_oe, sdo_oe}, 4'b1100);
    chk(rdy_bad == 0, "R10 ready only after byte, clock high", rdy_bad, 0);
    chk(low_bad == 0, "R8 low half period", low_bad, 0);
    if (abort_case) begin
      chk(err && !ok, "R2 abort flags", {ok, err}, 2'b01);
      chk(fall_cnt == 0, "R2 no clocks on abort", fall_cnt, 0);
    end else begin
      chk(settle == SETC, "R3 settle delay", settle, SETC);
      chk(lead_r == LEAD, "R4 leading clocks", lead_r, LEAD);
      chk(data_r == 8 * len, busy_start ? "R11 data bits after busy start" : "R5 data bits",
          data_r, 8 * len);
      for (int i = 0; i < len; i++)
        chk(cap[i] == pat(r, i), "R5 byte msb first", cap[i], pat(r, i));
      chk(sdo_bad == 0, "R5 data changes while clock low", sdo_bad, 0);
      chk(trail_r == TRAIL, "R6 trailing clocks", trail_r, TRAIL);
      chk(ok == want_done && err == !want_done, "R7 result flags", {ok, err},
          want_done ? 2 : 1);
    end
    ok0 = ok; err0 = err;
    done_in = !done_in;
    repeat (10) @(negedge clk);
    chk(ok == ok0 && err == err0, "R7 flags sticky", {ok, err}, {ok0, err0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(creset_n && cs_n && !busy && !ok && !err && !sclk_oe && !sdo_oe && !s_ready,
        "R9 reset state", {creset_n, cs_n, busy, ok, err}, 5'b11000);
    rst_n = 1;
    @(negedge clk);
    for (int g = 0; g < 2; g++)
      for (int l = 0; l <= 5; l++)
        run(g * 6 + l, l, g * 3, 1'b1, 1'b0, 1'b0);
    run(20, 2, 0, 1'b0, 1'b0, 1'b0);
    run(21, 0, 0, 1'b0, 1'b1, 1'b0);
    run(22, 3, 2, 1'b1, 1'b0, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule